// File: doc/BRIEF.md
# Pairwise Add-Accumulate Long Unit

This unit is one execution stage of a SIMD datapath. It takes a source vector of 8-, 16- or 32-bit integer elements and splits it into neighbouring pairs. It widens both members of each pair to twice the element width and adds them together. It then adds that sum into the matching double-width element of an accumulator vector. Each source element is either sign-extended or zero-extended before the addition, depending on the selected type.

The operation covers either one 64-bit lane or two 64-bit lanes, and each lane is worked independently. The unit also decodes the instruction fields that matter to it. It forms the 5-bit destination and source register numbers, and it flags encodings that are illegal. There are two illegal cases: a reserved element-size code, and an odd register number on a two-lane operation. When an encoding is flagged, the accumulator comes back unmodified.

Requests enter through a valid/ready handshake. The result appears one cycle after acceptance, whatever the data values are. The register numbers are carried along with the result so that it can be written back.

Top module: `pair_accum_long`

## Requirements
- R1: The size code selects the element width as 8 << size, so codes 0, 1 and 2 give 8, 16 and 32 bits. Code 3 raises `out_undef`.
- R2: With element width W, result element e occupies bits [2W*e +: 2W] of its 64-bit lane. Its value is the accumulator element e plus source elements 2e and 2e+1, where source element k occupies bits [W*k +: W]. The sum wraps modulo 2^(2W) and does not carry into the neighbouring element.
- R3: With `op_unsigned`=1 the source elements are zero-extended before the addition. With `op_unsigned`=0 they are sign-extended.
- R4: With `quad`=0 only bits [63:0] are processed, and `out_data[127:64]` equals `acc_vec[127:64]`.
- R5: With `quad`=1 both 64-bit lanes are processed by the R2 rule, and no value crosses from one lane into the other.
- R6: The register numbers are {dst_ext, dst_fld} and {src_ext, src_fld}. With `quad`=1, a set bit 0 in either number raises `out_undef`. With `quad`=0, odd numbers are legal.
- R7: Whenever `out_undef` is high, `out_data` equals the accepted `acc_vec`.
- R8: A request is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its result is presented with `out_valid` high right after the next edge, for every data value.
- R9: `in_ready` is high when no result is held or when `out_ready` is high. A result held with `out_ready` low keeps `out_valid`, `out_data` and `out_undef` unchanged.
- R10: After reset, `out_valid`, `out_undef` and `out_data` are zero and `in_ready` is high.
- R11: `out_dst_reg` and `out_src_reg` return the 5-bit register numbers of the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| size | input | 2 | Element size code |
| op_unsigned | input | 1 | 1 = zero-extend, 0 = sign-extend |
| quad | input | 1 | 1 = two lanes, 0 = lower lane only |
| dst_ext | input | 1 | Destination register number, bit 4 |
| dst_fld | input | 4 | Destination register number, bits 3:0 |
| src_ext | input | 1 | Source register number, bit 4 |
| src_fld | input | 4 | Source register number, bits 3:0 |
| src_vec | input | 128 | Source elements |
| acc_vec | input | 128 | Accumulator elements |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 128 | Updated accumulator |
| out_undef | output | 1 | Illegal encoding flag |
| out_dst_reg | output | 5 | Destination register number |
| out_src_reg | output | 5 | Source register number |

## Verification
The bench sweeps every size code, both signedness settings, both lane counts and all four register-parity combinations. It uses data patterns chosen to expose specific faults:
- All-ones sources and accumulators make every element wrap. A carry leaking into the next element, or across the lane boundary, shows up as a wrong neighbour.
- Sources built from element minimums (values like 0x80) catch a design that extends with the wrong polarity, or that sign-extends unsigned data.

The sweep also checks several illegal cases:
- An odd register number on a one-lane operation must stay legal, so a design that applies the alignment rule too broadly is caught.
- A size code of 3 must return the accumulator unchanged, so a design that leaks a computed value is caught.
- A one-lane operation must pass the upper half through, so a design that overwrites it is caught.

A back-pressure sequence checks that a held result stays stable and that a second request is not accepted early.

// File: rtl/pal_pkg.sv
package pal_pkg;
   // Number of legal element-size codes and width of the narrowest element.
   localparam int PAL_NUM_ESIZE = 3;
   localparam int PAL_BASE_ESIZE = 8;

   // Element width in bits for a size code.
   function automatic int pal_esize(input int code);
      return PAL_BASE_ESIZE << code;
   endfunction
endpackage

// File: rtl/pal_decode.sv
module pal_decode #(
   parameter int SIZE_W    = 2,
   parameter int FLD_W     = 4,
   parameter int NUM_LANES = 2,
   localparam int IDX_W    = FLD_W + 1
) (
   input  logic [SIZE_W-1:0] size,
   input  logic              quad,
   input  logic              dst_ext,
   input  logic [FLD_W-1:0]  dst_fld,
   input  logic              src_ext,
   input  logic [FLD_W-1:0]  src_fld,
   output logic [IDX_W-1:0]  dst_idx,
   output logic [IDX_W-1:0]  src_idx,
   output logic [NUM_LANES-1:0] lane_on,
   output logic              undef
);
   import pal_pkg::*;

   logic size_bad;
   logic align_bad;

   // Register numbers: the extension bit is the most significant bit.
   assign dst_idx = {dst_ext, dst_fld};
   assign src_idx = {src_ext, src_fld};

   // Codes at or above the number of legal sizes are reserved.
   assign size_bad  = (32'(size) >= PAL_NUM_ESIZE);
   // A two-lane operation needs even-aligned register pairs.
   assign align_bad = quad & (dst_idx[0] | src_idx[0]);
   assign undef     = size_bad | align_bad;

   // Lane 0 is always active; the upper lanes follow the quad bit.
   for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane_on
      if (l == 0) begin : g_base
         assign lane_on[l] = 1'b1;
      end else begin : g_upper
         assign lane_on[l] = quad;
      end
   end
endmodule

// File: rtl/pal_lane.sv
module pal_lane #(
   parameter int LANE_W = 64,
   parameter int SIZE_W = 2
) (
   input  logic [LANE_W-1:0] src,
   input  logic [LANE_W-1:0] acc,
   input  logic [SIZE_W-1:0] size,
   input  logic              uns,
   output logic [LANE_W-1:0] res
);
   import pal_pkg::*;

   if (LANE_W % (2 * pal_esize(PAL_NUM_ESIZE - 1)) != 0) begin : g_bad_lane
      $error("pal_lane: LANE_W must hold whole widest result elements");
   end

   // One full-lane result per legal element size, all computed in parallel.
   logic [LANE_W-1:0] var_res [PAL_NUM_ESIZE];

   for (genvar g = 0; g < PAL_NUM_ESIZE; g++) begin : g_size
      localparam int ESZ = pal_esize(g);
      localparam int RW  = 2 * ESZ;
      localparam int NP  = LANE_W / RW;
      for (genvar p = 0; p < NP; p++) begin : g_pair
         logic [ESZ-1:0] lo_el;
         logic [ESZ-1:0] hi_el;
         logic [RW-1:0]  lo_wide;
         logic [RW-1:0]  hi_wide;
         assign lo_el   = src[p*RW +: ESZ];
         assign hi_el   = src[p*RW+ESZ +: ESZ];
         // The fill bits are the top bit for signed data and zero for unsigned data.
         assign lo_wide = {{ESZ{~uns & lo_el[ESZ-1]}}, lo_el};
         assign hi_wide = {{ESZ{~uns & hi_el[ESZ-1]}}, hi_el};
         // The sum is truncated to the double width, so it wraps and cannot carry outward.
         assign var_res[g][p*RW +: RW] = acc[p*RW +: RW] + lo_wide + hi_wide;
      end
   end

   always_comb begin
      res = acc;
      for (int g = 0; g < PAL_NUM_ESIZE; g++) begin
         if (size == SIZE_W'(g)) res = var_res[g];
      end
   end
endmodule

// File: rtl/pal_stage.sv
module pal_stage #(
   parameter int DATA_W = 128,
   parameter int IDX_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] d_data,
   input  logic              d_undef,
   input  logic [IDX_W-1:0]  d_dst,
   input  logic [IDX_W-1:0]  d_src,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] q_data,
   output logic              q_undef,
   output logic [IDX_W-1:0]  q_dst,
   output logic [IDX_W-1:0]  q_src
);
   logic take;

   assign in_ready = ~out_valid | out_ready;
   assign take     = in_valid & in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         q_data    <= '0;
         q_undef   <= 1'b0;
         q_dst     <= '0;
         q_src     <= '0;
      end else begin
         if (take) begin
            out_valid <= 1'b1;
            q_data    <= d_data;
            q_undef   <= d_undef;
            q_dst     <= d_dst;
            q_src     <= d_src;
         end else if (out_ready) begin
            out_valid <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/pair_accum_long.sv
module pair_accum_long #(
   parameter int LANE_W    = 64,
   parameter int NUM_LANES = 2,
   parameter int SIZE_W    = 2,
   parameter int FLD_W     = 4,
   localparam int VEC_W    = LANE_W * NUM_LANES,
   localparam int IDX_W    = FLD_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [SIZE_W-1:0] size,
   input  logic              op_unsigned,
   input  logic              quad,
   input  logic              dst_ext,
   input  logic [FLD_W-1:0]  dst_fld,
   input  logic              src_ext,
   input  logic [FLD_W-1:0]  src_fld,
   input  logic [VEC_W-1:0]  src_vec,
   input  logic [VEC_W-1:0]  acc_vec,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [VEC_W-1:0]  out_data,
   output logic              out_undef,
   output logic [IDX_W-1:0]  out_dst_reg,
   output logic [IDX_W-1:0]  out_src_reg
);
   if (NUM_LANES < 1) begin : g_bad_lanes
      $error("pair_accum_long: NUM_LANES must be at least 1");
   end
   if (SIZE_W < 2) begin : g_bad_size
      $error("pair_accum_long: SIZE_W must encode three sizes");
   end

   logic [IDX_W-1:0]     dst_idx;
   logic [IDX_W-1:0]     src_idx;
   logic [NUM_LANES-1:0] lane_on;
   logic                 undef;
   logic [VEC_W-1:0]     next_data;

   pal_decode #(
      .SIZE_W(SIZE_W), .FLD_W(FLD_W), .NUM_LANES(NUM_LANES)
   ) u_dec (
      .size(size), .quad(quad),
      .dst_ext(dst_ext), .dst_fld(dst_fld),
      .src_ext(src_ext), .src_fld(src_fld),
      .dst_idx(dst_idx), .src_idx(src_idx),
      .lane_on(lane_on), .undef(undef)
   );

   for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      logic [LANE_W-1:0] lane_res;
      pal_lane #(.LANE_W(LANE_W), .SIZE_W(SIZE_W)) u_lane (
         .src(src_vec[l*LANE_W +: LANE_W]),
         .acc(acc_vec[l*LANE_W +: LANE_W]),
         .size(size),
         .uns(op_unsigned),
         .res(lane_res)
      );
      // Inactive lanes and illegal encodings return the accumulator untouched.
      assign next_data[l*LANE_W +: LANE_W] =
         (lane_on[l] & ~undef) ? lane_res : acc_vec[l*LANE_W +: LANE_W];
   end

   pal_stage #(.DATA_W(VEC_W), .IDX_W(IDX_W)) u_stage (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready),
      .d_data(next_data), .d_undef(undef),
      .d_dst(dst_idx), .d_src(src_idx),
      .out_valid(out_valid), .out_ready(out_ready),
      .q_data(out_data), .q_undef(out_undef),
      .q_dst(out_dst_reg), .q_src(out_src_reg)
   );
endmodule

// File: rtl/pair_accum_long_chk.sv
module pair_accum_long_chk #(
   parameter int LANE_W = 64,
   parameter int VEC_W  = 128,
   parameter int SIZE_W = 2,
   parameter int FLD_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic [SIZE_W-1:0] size,
   input logic              quad,
   input logic [FLD_W-1:0]  dst_fld,
   input logic [FLD_W-1:0]  src_fld,
   input logic [VEC_W-1:0]  acc_vec,
   input logic              out_valid,
   input logic              out_ready,
   input logic [VEC_W-1:0]  out_data,
   input logic              out_undef
);
   logic take;
   assign take = in_valid & in_ready;

   p_size_undef_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (take && size == SIZE_W'(3)) |=> out_undef);

   p_upper_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !quad) |=> out_data[VEC_W-1:LANE_W] == $past(acc_vec[VEC_W-1:LANE_W]));

   p_align_undef_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (take && quad && (dst_fld[0] || src_fld[0])) |=> out_undef);

   p_undef_keeps_acc_r7: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (!out_undef || out_data == $past(acc_vec)));

   p_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> out_valid);

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_undef)));

   p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);
endmodule

bind pair_accum_long pair_accum_long_chk #(
   .LANE_W(LANE_W), .VEC_W(VEC_W), .SIZE_W(SIZE_W), .FLD_W(FLD_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .size(size), .quad(quad), .dst_fld(dst_fld), .src_fld(src_fld),
   .acc_vec(acc_vec), .out_valid(out_valid), .out_ready(out_ready),
   .out_data(out_data), .out_undef(out_undef)
);

// File: tb/tb_pair_accum_long.sv
`timescale 1ns/1ps
module tb_pair_accum_long;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [1:0]   size = '0;
   logic         op_unsigned = 1'b0;
   logic         quad = 1'b0;
   logic         dst_ext = 1'b0;
   logic [3:0]   dst_fld = '0;
   logic         src_ext = 1'b0;
   logic [3:0]   src_fld = '0;
   logic [127:0] src_vec = '0;
   logic [127:0] acc_vec = '0;
   logic         out_valid;
   logic         out_ready = 1'b1;
   logic [127:0] out_data;
   logic         out_undef;
   logic [4:0]   out_dst_reg;
   logic [4:0]   out_src_reg;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   pair_accum_long dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .size(size), .op_unsigned(op_unsigned), .quad(quad),
      .dst_ext(dst_ext), .dst_fld(dst_fld), .src_ext(src_ext), .src_fld(src_fld),
      .src_vec(src_vec), .acc_vec(acc_vec), .out_valid(out_valid),
      .out_ready(out_ready), .out_data(out_data), .out_undef(out_undef),
      .out_dst_reg(out_dst_reg), .out_src_reg(out_src_reg)
   );

   task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Reference model built from the requirements: pairwise sum, widen, accumulate.
   function automatic logic [127:0] model(input logic [127:0] s, input logic [127:0] a,
                                          input int sz, input bit uns, input bit q,
                                          input bit bad);
      logic [127:0] res;
      int es, rw, pos;
      logic [63:0] m1, m2, x, y, ac, sum;
      if (sz == 3 || bad) return a;
      es  = 8 << sz;
      rw  = 2 * es;
      res = a;
      m1  = (64'd1 << es) - 64'd1;
      m2  = (rw == 64) ? '1 : ((64'd1 << rw) - 64'd1);
      for (int l = 0; l < (q ? 2 : 1); l++) begin
         for (int e = 0; e < 64 / rw; e++) begin
            pos = l * 64 + e * rw;
            x   = 64'(s >> pos) & m1;
            y   = 64'(s >> (pos + es)) & m1;
            if (!uns && x[es-1]) x = x | ~m1;
            if (!uns && y[es-1]) y = y | ~m1;
            ac  = 64'(a >> pos) & m2;
            sum = (ac + x + y) & m2;
            res = (res & ~({64'd0, m2} << pos)) | ({64'd0, sum} << pos);
         end
      end
      return res;
   endfunction

   function automatic logic [127:0] mix(input logic [127:0] v);
      logic [127:0] r;
      r = v ^ (v << 13);
      r = r ^ (r >> 7);
      r = r ^ (r << 17);
      return r;
   endfunction

   task automatic send;
      @(negedge clk);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      logic [127:0] seed, s_a, exp_v;
      bit bad;
      repeat (3) @(negedge clk);
      // R10: state after reset
      check("R10 out_valid", {127'd0, out_valid}, 128'd0);
      check("R10 out_undef", {127'd0, out_undef}, 128'd0);
      check("R10 out_data", out_data, 128'd0);
      check("R10 in_ready", {127'd0, in_ready}, 128'd1);
      rst_n = 1'b1;

      // R2: hand-worked example, signed 16-bit elements, one lane.
      size = 2'd1; op_unsigned = 1'b0; quad = 1'b0;
      src_vec = {64'd0, 16'd4, 16'd3, 16'hFFFE, 16'hFFFF};
      acc_vec = {64'h1234, 32'd0, 32'd10};
      send();
      check("R2 worked example", out_data, {64'h1234, 32'd7, 32'd7});

      seed = 128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0;
      for (int sz = 0; sz < 4; sz++) begin
         for (int u = 0; u < 2; u++) begin
            for (int q = 0; q < 2; q++) begin
               for (int p = 0; p < 6; p++) begin
                  for (int ix = 0; ix < 4; ix++) begin
                     string tag;
                     seed = mix(seed);
                     case (p)
                        0: begin src_vec = '0; acc_vec = '1; end
                        1: begin src_vec = '1; acc_vec = '1; end
                        2: begin src_vec = {16{8'h80}}; acc_vec = {16{8'h7F}}; end
                        3: begin src_vec = {4{32'h8000_0000}}; acc_vec = {2{64'h8000_0000_8000_0000}}; end
                        default: begin src_vec = seed; acc_vec = mix(seed ^ 128'h55); end
                     endcase
                     size = 2'(sz); op_unsigned = u[0]; quad = q[0];
                     dst_fld = {3'(p), ix[0]}; dst_ext = ix[1];
                     src_fld = {3'(ix + p), ix[1]}; src_ext = ix[0];
                     bad = (q == 1) && (ix != 0);
                     exp_v = model(src_vec, acc_vec, sz, u[0], q[0], bad);
                     send();
                     check("R8 out_valid one cycle after accept", {127'd0, out_valid}, 128'd1);
                     check("R11 register numbers", {118'd0, out_dst_reg, out_src_reg},
                           {118'd0, dst_ext, dst_fld, src_ext, src_fld});
                     if (sz == 3) begin
                        check("R1 reserved size flagged", {127'd0, out_undef}, 128'd1);
                        check("R7 size-3 keeps accumulator", out_data, acc_vec);
                     end else if (bad) begin
                        check("R6 odd register on quad flagged", {127'd0, out_undef}, 128'd1);
                        check("R7 misaligned keeps accumulator", out_data, acc_vec);
                     end else begin
                        if (q == 0) tag = "R6 odd register legal on one lane";
                        else tag = "R6 even registers legal";
                        check(tag, {127'd0, out_undef}, 128'd0);
                        if (u == 1) tag = "R3 zero-extended accumulate";
                        else if (q == 1) tag = "R5 two-lane accumulate";
                        else tag = "R2 signed accumulate";
                        check(tag, out_data, exp_v);
                        if (q == 0) check("R4 upper half passes", {64'd0, out_data[127:64]},
                                          {64'd0, acc_vec[127:64]});
                     end
                  end
               end
            end
         end
      end
      @(negedge clk);
      check("R8 out_valid drops when idle", {127'd0, out_valid}, 128'd0);

      // R9: back-pressure holds the result and stalls the next request.
      size = 2'd0; op_unsigned = 1'b1; quad = 1'b1;
      dst_fld = 4'd2; src_fld = 4'd4; dst_ext = 1'b0; src_ext = 1'b0;
      src_vec = {16{8'h11}}; acc_vec = '0;
      s_a = model(src_vec, acc_vec, 0, 1'b1, 1'b1, 1'b0);
      @(negedge clk);
      out_ready = 1'b0;
      send();
      check("R9 in_ready low while held", {127'd0, in_ready}, 128'd0);
      src_vec = {16{8'h22}};
      exp_v = model(src_vec, acc_vec, 0, 1'b1, 1'b1, 1'b0);
      in_valid = 1'b1;
      @(negedge clk);
      check("R9 held result stable", out_data, s_a);
      check("R9 out_valid held", {127'd0, out_valid}, 128'd1);
      out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R9 next request taken after release", out_data, exp_v);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule